// File: doc/BRIEF.md
# Class-of-Service Priority Escalation Arbiter

This block picks one pending memory command per cycle from a set of requesters. Each requester presents a valid bit and a master connection ID. The ID is compared against two service classes, and each class holds three programmable slots. A slot has an ID, a don't-care mask and a 3-bit priority level, where 0 is the most urgent and 7 the least. The level of the first slot that matches becomes the requester's level. An ID that no slot matches gets level 7. The lowest level wins, and ties go round-robin.

To keep a low-priority class from starving, each class has its own escalation timer programmed with a value N. The timer counts the cycles in which that class has a command waiting that has not been served. Once N×16 such cycles have passed, every command of the class is treated as level 0 until one of them is granted. The timer then restarts from zero.

The grant is combinational from the current requests and configuration. The round-robin pointer and the escalation timers are the only state.

Top module: `cos_arb`

## Requirements
- R1: `grant` has at most one bit set. It has exactly one bit set in any cycle in which at least one `req_valid` bit is 1, and that bit is a valid requester. With no valid request, `grant` is 0 and `grant_lvl` is 0.
- R2: A slot matches an ID when the slot enable bit is 1 and every ID bit whose mask bit is 0 equals the slot's ID bit; mask bits that are 1 are ignored. The matching slot's 3-bit level applies, and a numerically lower level wins. `grant_lvl` shows the effective level of the granted requester.
- R3: Slots are searched class 0 before class 1, and lower slot index first within a class. The first match alone decides the level and the class.
- R4: A valid ID that matches no slot is arbitrated at level 7.
- R5: Among requesters at the same best level, the search starts at the index after the last granted one and wraps around. After reset the search starts at index 0.
- R6: For class c, consider the cycles in which a command of the class is pending and no command of the class is granted. From the cycle after 16×N such consecutive cycles (N = `cfg_raise_n` field c, N > 0), `raise_active[c]` is 1 and the class's commands arbitrate at level 0 until a command of the class is granted.
- R7: The class timer restarts from zero after any cycle in which the class has no pending command or is granted. N = 0 disables escalation for that class.
- R8: After a synchronous active-low reset, `grant` is 0 with no requests, `raise_active` is 0, and the round-robin pointer is at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Pending command per requester |
| req_id | input | NUM_REQ*ID_W | Connection ID per requester, requester i at bits [i*ID_W +: ID_W] |
| cfg_slot_en | input | NUM_CLASS*SLOTS | Slot enable, slot s of class c at bit c*SLOTS+s |
| cfg_slot_id | input | NUM_CLASS*SLOTS*ID_W | Slot ID, same slot order |
| cfg_slot_mask | input | NUM_CLASS*SLOTS*ID_W | Slot don't-care mask (1 = ignore bit) |
| cfg_slot_lvl | input | NUM_CLASS*SLOTS*3 | Slot priority level, 0 most urgent |
| cfg_raise_n | input | NUM_CLASS*RAISE_W | Escalation period N per class (N×16 cycles, 0 = off) |
| grant | output | NUM_REQ | One-hot grant of this cycle |
| grant_lvl | output | 3 | Effective level of the granted requester |
| raise_active | output | NUM_CLASS | Class currently escalated to level 0 |

## Verification
The outputs `grant` and `grant_lvl` follow the inputs in the same cycle. The bench therefore drives each new stimulus on the falling edge and checks it a moment later, before the next rising edge. Round-robin results depend on the grants already made, so each tie check expects the grant that falls one cycle later in the rotation, counted from a reset given at the start of the task. Escalation appears in the cycle after the 16×N-th rising edge with the class waiting, so the bench counts cycles from the first falling edge with the request applied. It checks the cycle just before the raise, the raise cycle and the cycle after it.

// File: rtl/cos_arb_pkg.sv
// Package: shared constants and types for the class-of-service arbiter.
// Assumes 3-bit priority levels with 0 the most urgent.
package cos_arb_pkg;
    localparam int LVL_W      = 3;
    localparam int LVL_LOWEST = 7;
    localparam int TICK_SHIFT = 4;   // escalation unit is 2**4 = 16 cycles
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/cos_id_classify.sv
// Module: maps one requester's connection ID onto a class and level.
// Searches class 0 before class 1 and the lower slot first; the first match
// decides. An escalated class arbitrates at level 0. No match gives level 7.
// Assumes the configuration is stable while it is used.
module cos_id_classify
    import cos_arb_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int NUM_CLASS = 2,
    parameter int SLOTS     = 3
) (
    input  logic [ID_W-1:0]                 req_id,
    input  logic [NUM_CLASS*SLOTS-1:0]      cfg_slot_en,
    input  logic [NUM_CLASS*SLOTS*ID_W-1:0] cfg_slot_id,
    input  logic [NUM_CLASS*SLOTS*ID_W-1:0] cfg_slot_mask,
    input  logic [NUM_CLASS*SLOTS*LVL_W-1:0] cfg_slot_lvl,
    input  logic [NUM_CLASS-1:0]            raised,
    output logic [NUM_CLASS-1:0]            cls_hit,
    output lvl_t                            eff_lvl
);
    // First-match search over all slots, then apply class escalation.
    always_comb begin
        logic found;
        found   = 1'b0;
        cls_hit = '0;
        eff_lvl = lvl_t'(LVL_LOWEST);
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (!found && cfg_slot_en[c*SLOTS+s] &&
                    (((req_id ^ cfg_slot_id[(c*SLOTS+s)*ID_W +: ID_W]) &
                      ~cfg_slot_mask[(c*SLOTS+s)*ID_W +: ID_W]) == '0)) begin
                    found      = 1'b1;
                    cls_hit[c] = 1'b1;
                    eff_lvl    = cfg_slot_lvl[(c*SLOTS+s)*LVL_W +: LVL_W];
                end
            end
        end
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (cls_hit[c] && raised[c]) eff_lvl = '0;
        end
    end
endmodule

// File: rtl/cos_raise_timer.sv
// Module: escalation timer of one service class.
// Counts cycles with the class waiting and not served, saturating at N*16.
// It restarts after a cycle with nothing pending or with a grant to the
// class. Assumes N = 0 means escalation is off.
module cos_raise_timer
    import cos_arb_pkg::*;
#(
    parameter int RAISE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pending,
    input  logic               granted,
    input  logic [RAISE_W-1:0] raise_n,
    output logic               raised
);
    localparam int CNT_W = RAISE_W + TICK_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Threshold in cycles and the escalation flag it yields.
    always_comb begin
        limit  = {raise_n, {TICK_SHIFT{1'b0}}};
        raised = (raise_n != '0) && (cnt_q >= limit);
    end

    // Wait counter: clear on idle or service, count up to the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!pending || granted) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cos_rr_pick.sv
// Module: picks the lowest effective level among valid requesters and
// breaks ties round-robin. The pointer moves past each granted index.
// Assumes NUM_REQ >= 2.
module cos_rr_pick
    import cos_arb_pkg::*;
#(
    parameter int NUM_REQ = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       valid,
    input  logic [NUM_REQ*LVL_W-1:0] lvl,
    output logic [NUM_REQ-1:0]       grant,
    output lvl_t                     grant_lvl
);
    localparam int PTR_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;
    lvl_t             best;

    // Best level, then the first candidate at or after the pointer.
    always_comb begin
        logic found;
        int   idx;
        best  = lvl_t'(LVL_LOWEST);
        for (int i = 0; i < NUM_REQ; i++) begin
            if (valid[i] && (lvl[i*LVL_W +: LVL_W] < best)) best = lvl[i*LVL_W +: LVL_W];
        end
        found     = 1'b0;
        grant     = '0;
        grant_lvl = '0;
        ptr_d     = ptr_q;
        for (int off = 0; off < NUM_REQ; off++) begin
            idx = int'(ptr_q) + off;
            if (idx >= NUM_REQ) idx = idx - NUM_REQ;
            if (!found && valid[idx] && (lvl[idx*LVL_W +: LVL_W] == best)) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                grant_lvl  = best;
                ptr_d      = (idx == NUM_REQ-1) ? '0 : PTR_W'(idx + 1);
            end
        end
    end

    // Round-robin pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/cos_arb.sv
// Module: top of the class-of-service priority escalation arbiter.
// Classifies every requester, runs one escalation timer per class and
// grants one requester per cycle. The grant is combinational.
// Assumes the configuration inputs change only while idle.
module cos_arb
    import cos_arb_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int ID_W      = 8,
    parameter int NUM_CLASS = 2,
    parameter int SLOTS     = 3,
    parameter int RAISE_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REQ-1:0]             req_valid,
    input  logic [NUM_REQ*ID_W-1:0]        req_id,
    input  logic [NUM_CLASS*SLOTS-1:0]     cfg_slot_en,
    input  logic [NUM_CLASS*SLOTS*ID_W-1:0] cfg_slot_id,
    input  logic [NUM_CLASS*SLOTS*ID_W-1:0] cfg_slot_mask,
    input  logic [NUM_CLASS*SLOTS*3-1:0]   cfg_slot_lvl,
    input  logic [NUM_CLASS*RAISE_W-1:0]   cfg_raise_n,
    output logic [NUM_REQ-1:0]             grant,
    output logic [2:0]                     grant_lvl,
    output logic [NUM_CLASS-1:0]           raise_active
);
    logic [NUM_CLASS-1:0]     hit [NUM_REQ];
    logic [NUM_REQ*LVL_W-1:0] req_lvl;
    logic [NUM_CLASS-1:0]     cls_pending;
    logic [NUM_CLASS-1:0]     cls_granted;
    lvl_t                     pick_lvl;

    // One classifier per requester.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_cls
        cos_id_classify #(
            .ID_W(ID_W), .NUM_CLASS(NUM_CLASS), .SLOTS(SLOTS)
        ) u_classify (
            .req_id        (req_id[i*ID_W +: ID_W]),
            .cfg_slot_en   (cfg_slot_en),
            .cfg_slot_id   (cfg_slot_id),
            .cfg_slot_mask (cfg_slot_mask),
            .cfg_slot_lvl  (cfg_slot_lvl),
            .raised        (raise_active),
            .cls_hit       (hit[i]),
            .eff_lvl       (req_lvl[i*LVL_W +: LVL_W])
        );
    end

    // Per-class pending and served flags.
    always_comb begin
        cls_pending = '0;
        cls_granted = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_valid[i]) cls_pending = cls_pending | hit[i];
            if (grant[i])     cls_granted = cls_granted | hit[i];
        end
    end

    // One escalation timer per class.
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_tmr
        cos_raise_timer #(.RAISE_W(RAISE_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .pending (cls_pending[c]),
            .granted (cls_granted[c]),
            .raise_n (cfg_raise_n[c*RAISE_W +: RAISE_W]),
            .raised  (raise_active[c])
        );
    end

    cos_rr_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .lvl       (req_lvl),
        .grant     (grant),
        .grant_lvl (pick_lvl)
    );

    // Drive the level output from the picker.
    always_comb grant_lvl = pick_lvl;
endmodule

// File: rtl/cos_arb_chk.sv
// Module: assertion checker for cos_arb, attached with bind below.
module cos_arb_chk #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_CLASS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_REQ-1:0]   req_valid,
    input logic [NUM_REQ-1:0]   grant,
    input logic [2:0]           grant_lvl,
    input logic [NUM_CLASS-1:0] raise_active,
    input logic [NUM_CLASS-1:0] cls_pending,
    input logic [NUM_CLASS-1:0] cls_granted
);
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_iff_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) == (|grant));
    p_grant_is_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);
    p_raised_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raise_active & cls_pending)) |-> (grant_lvl == 3'd0));

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        p_raise_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (raise_active[c] && cls_granted[c]) |=> !raise_active[c]);
        p_raise_needs_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raise_active[c]) |-> $past(cls_pending[c]));
    end
endmodule

bind cos_arb cos_arb_chk #(.NUM_REQ(NUM_REQ), .NUM_CLASS(NUM_CLASS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .grant        (grant),
    .grant_lvl    (grant_lvl),
    .raise_active (raise_active),
    .cls_pending  (cls_pending),
    .cls_granted  (cls_granted)
);

// File: tb/cos_arb_tb.sv
// Directed bench for cos_arb: one task per scenario.
module cos_arb_tb;
    localparam int CLK_P = 10;
    localparam int NR = 4, IW = 8, NC = 2, SL = 3, RW = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NR-1:0]       req_valid = '0;
    logic [NR*IW-1:0]    req_id = '0;
    logic [NC*SL-1:0]    cfg_slot_en = '0;
    logic [NC*SL*IW-1:0] cfg_slot_id = '0;
    logic [NC*SL*IW-1:0] cfg_slot_mask = '0;
    logic [NC*SL*3-1:0]  cfg_slot_lvl = '0;
    logic [NC*RW-1:0]    cfg_raise_n = '0;
    logic [NR-1:0]       grant;
    logic [2:0]          grant_lvl;
    logic [NC-1:0]       raise_active;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cos_arb #(.NUM_REQ(NR), .ID_W(IW), .NUM_CLASS(NC), .SLOTS(SL), .RAISE_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .cfg_slot_en(cfg_slot_en), .cfg_slot_id(cfg_slot_id),
        .cfg_slot_mask(cfg_slot_mask), .cfg_slot_lvl(cfg_slot_lvl),
        .cfg_raise_n(cfg_raise_n), .grant(grant), .grant_lvl(grant_lvl),
        .raise_active(raise_active));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Move to the next falling edge: drive point of a new cycle.
    task automatic next_cyc();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        next_cyc();
        rst_n = 1'b0; req_valid = '0;
        repeat (2) @(posedge clk);
        next_cyc();
        rst_n = 1'b1;
    endtask

    task automatic clear_cfg();
        cfg_slot_en = '0; cfg_slot_id = '0; cfg_slot_mask = '0;
        cfg_slot_lvl = '0; cfg_raise_n = '0;
    endtask

    task automatic set_slot(input int c, input int s, input logic [7:0] id,
                            input logic [7:0] mask, input logic [2:0] lvl);
        cfg_slot_en[c*SL+s] = 1'b1;
        cfg_slot_id[(c*SL+s)*IW +: IW]   = id;
        cfg_slot_mask[(c*SL+s)*IW +: IW] = mask;
        cfg_slot_lvl[(c*SL+s)*3 +: 3]    = lvl;
    endtask

    task automatic set_req(input int i, input logic v, input logic [7:0] id);
        req_valid[i] = v;
        req_id[i*IW +: IW] = id;
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        check("R8 grant idle", int'(grant), 0);
        check("R8 raise_active", int'(raise_active), 0);
        check("R1 level idle", int'(grant_lvl), 0);
    endtask

    task automatic t_levels();
        do_reset(); clear_cfg();
        set_slot(0, 0, 8'h10, 8'h00, 3'd3);
        set_slot(0, 1, 8'h20, 8'h00, 3'd1);
        set_req(0, 1, 8'h10); set_req(1, 1, 8'h20);
        settle();
        check("R2 lower level wins", int'(grant), 4'b0010);
        check("R2 level shown", int'(grant_lvl), 1);
        check("R1 one-hot", $countones(grant), 1);
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_mask();
        do_reset(); clear_cfg();
        set_slot(0, 0, 8'h40, 8'h0F, 3'd2);
        set_slot(0, 1, 8'h77, 8'h00, 3'd3);
        set_req(0, 1, 8'h77); set_req(1, 1, 8'h4A);
        settle();
        check("R2 masked match", int'(grant), 4'b0010);
        check("R2 masked level", int'(grant_lvl), 2);
        next_cyc(); set_req(1, 1, 8'h5A);
        settle();
        check("R2 unmasked bit differs", int'(grant), 4'b0001);
        next_cyc(); cfg_slot_en[0] = 1'b0; set_req(1, 1, 8'h4A);
        settle();
        check("R2 disabled slot", int'(grant), 4'b0001);
        check("R2 disabled slot level", int'(grant_lvl), 3);
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_first_match();
        do_reset(); clear_cfg();
        set_slot(0, 2, 8'h30, 8'h00, 3'd6);
        set_slot(1, 0, 8'h30, 8'h00, 3'd0);
        set_slot(1, 1, 8'h55, 8'h00, 3'd4);
        set_req(2, 1, 8'h30); set_req(3, 1, 8'h55);
        settle();
        check("R3 class0 slot decides", int'(grant), 4'b1000);
        check("R3 level", int'(grant_lvl), 4);
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_unmatched();
        do_reset(); clear_cfg();
        set_slot(0, 0, 8'h10, 8'h00, 3'd6);
        set_req(0, 1, 8'h99); set_req(1, 1, 8'h10);
        settle();
        check("R4 unmatched loses to 6", int'(grant), 4'b0010);
        next_cyc(); set_req(1, 0, 8'h10);
        settle();
        check("R4 unmatched alone", int'(grant), 4'b0001);
        check("R4 unmatched level", int'(grant_lvl), 7);
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_rr();
        int exp_seq [5] = '{1, 2, 4, 8, 1};
        do_reset(); clear_cfg();
        for (int i = 0; i < NR; i++) set_req(i, 1, 8'hE0);
        for (int k = 0; k < 5; k++) begin
            if (k > 0) next_cyc();
            settle();
            check("R5 rotation", int'(grant), exp_seq[k]);
        end
        next_cyc(); req_valid = 4'b0101;
        settle();
        check("R5 resume after pointer", int'(grant), 4'b0100);
        next_cyc();
        settle();
        check("R5 wrap", int'(grant), 4'b0001);
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_raise();
        do_reset(); clear_cfg();
        set_slot(0, 0, 8'h11, 8'h00, 3'd1);
        set_slot(1, 0, 8'h80, 8'h00, 3'd5);
        cfg_raise_n[RW +: RW] = 6'd1;
        set_req(0, 1, 8'h11); set_req(1, 1, 8'h80);
        for (int k = 0; k <= 18; k++) begin
            if (k > 0) next_cyc();
            settle();
            if (k == 15) begin
                check("R6 not yet raised", int'(raise_active), 0);
                check("R6 low class waits", int'(grant), 4'b0001);
            end
            if (k == 16) begin
                check("R6 raised", int'(raise_active), 2'b10);
                check("R6 raised class wins", int'(grant), 4'b0010);
                check("R6 raised level", int'(grant_lvl), 0);
            end
            if (k == 17) begin
                check("R7 restart after grant", int'(raise_active), 0);
                check("R7 normal order back", int'(grant), 4'b0001);
            end
        end
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_restart();
        do_reset(); clear_cfg();
        set_slot(0, 0, 8'h11, 8'h00, 3'd1);
        set_slot(1, 0, 8'h80, 8'h00, 3'd5);
        cfg_raise_n[RW +: RW] = 6'd1;
        set_req(0, 1, 8'h11); set_req(1, 1, 8'h80);
        repeat (10) next_cyc();
        req_valid[1] = 1'b0;
        next_cyc(); req_valid[1] = 1'b1;
        for (int j = 0; j <= 16; j++) begin
            if (j > 0) next_cyc();
            settle();
            if (j == 6)  check("R7 idle cycle restarts", int'(raise_active), 0);
            if (j == 15) check("R7 full wait after idle", int'(grant), 4'b0001);
            if (j == 16) check("R7 raise after fresh wait", int'(grant), 4'b0010);
        end
        next_cyc(); req_valid = '0;
    endtask

    task automatic t_n_zero();
        int seen = 0;
        do_reset(); clear_cfg();
        set_slot(0, 0, 8'h11, 8'h00, 3'd1);
        set_slot(1, 0, 8'h80, 8'h00, 3'd5);
        set_req(0, 1, 8'h11); set_req(1, 1, 8'h80);
        for (int k = 0; k < 40; k++) begin
            if (k > 0) next_cyc();
            settle();
            if (grant[1] || raise_active != '0) seen++;
        end
        check("R7 N=0 never raises", seen, 0);
        next_cyc(); req_valid = '0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_levels();
        t_mask();
        t_first_match();
        t_unmatched();
        t_rr();
        t_raise();
        t_restart();
        t_n_zero();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule